// File: doc/BRIEF.md
# Bus-Synchronized CPU Rate Controller

This block sets the operating rate of the CPU and the other bus masters in a microcontroller that has a reduced-speed mode. Software writes a 3-bit speed code. The block divides the base clock down to one of five slower rates by issuing a one-cycle clock-enable pulse. All logic stays on the base clock domain and uses enables only. Peripherals that do not master the bus get a separate enable that is asserted on every base clock.

A newly written code is held as pending. It becomes active only in a cycle that marks the end of a bus cycle, so an access in flight never sees its rate change partway through. When the active rate changes, the divider counter restarts, which makes the first divided period full length.

A side output converts an access length, counted in bus-master states, into base clocks at the active rate. This lets the surrounding logic and the bench predict how long an access lasts.

Top module: `cpu_rate_ctrl`

## Requirements
- R1: After reset, the active code is 000, `master_ce` is high on every base clock, and `acc_cycles` equals `acc_states`.
- R2: A code written with `sel_wr` is held as pending. `active_sel` keeps its old value for as long as `bus_end` stays low.
- R3: On a clock edge where `bus_end` is high, `active_sel` takes the pending value held before that edge. A write in that same cycle becomes active only at a later `bus_end`.
- R4: Nonzero codes give a divisor of 2 to the power of the code: 001=/2, 010=/4, 011=/8, 100=/16, 101=/32. Codes 110 and 111 act as /32. In divided mode, `master_ce` is a single-cycle pulse repeating every divisor cycles.
- R5: Code 000 means full speed: `master_ce` is high on every base clock.
- R6: When a `bus_end` edge changes the active code, the first `master_ce` pulse comes exactly divisor base clocks after that edge. Counting the sample just after the edge as the first, the pulse is at sample number divisor.
- R7: A `bus_end` edge whose pending code equals the active code leaves the pulse phase undisturbed.
- R8: `periph_ce` is high on every base clock, whatever the active code.
- R9: `acc_cycles` equals `acc_states` times the active divisor. For example, at /4, 4 states give 16 and 8 states give 32.
- R10: An asynchronous reset assertion during divided operation returns the block at once to full speed with active code 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_wr | input | 1 | Write strobe for the speed code |
| sel_wdata | input | SEL_W (3) | Speed code to store as pending |
| bus_end | input | 1 | High in the last cycle of the current bus cycle |
| acc_states | input | STATE_W (8) | Access length in bus-master states |
| master_ce | output | 1 | Clock enable for the CPU and other bus masters |
| periph_ce | output | 1 | Clock enable for non-master peripherals |
| active_sel | output | SEL_W (3) | Speed code currently in force |
| acc_cycles | output | STATE_W+MAX_SHIFT (13) | Base clocks for `acc_states` at the active divisor |

## Verification
The bench builds the block with its defaults: SEL_W=3, MAX_SHIFT=5 and STATE_W=8. With these values the whole 3-bit code space can be reached, including the two codes above 101 that saturate at /32. The longest divided period is 32 cycles, so one loop over every code can measure both the restart delay and the steady pulse spacing. The 13-bit access output also holds the largest product without clipping, which lets the bench compare it exactly against states times divisor.

// File: rtl/rate_pkg.sv
package rate_pkg;
  // Speed code to divider exponent; codes above the limit saturate.
  function automatic int unsigned sat_shift(int unsigned code, int unsigned max_sh);
    return (code > max_sh) ? max_sh : code;
  endfunction
endpackage

// File: rtl/rate_sel_regs.sv
module rate_sel_regs #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             bus_end,
  output logic [SEL_W-1:0] act_sel,
  output logic             restart
);
  logic [SEL_W-1:0] pend_q, pend_d;
  logic [SEL_W-1:0] act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    if (sel_wr) pend_d = sel_wdata;
    act_d = act_q;
    if (bus_end) act_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign act_sel = act_q;
  assign restart = bus_end && (pend_q != act_q);

  // R2: no bus-cycle end, no change of the active code
  a_r2_hold_until_end: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_end |=> $stable(act_q));
  // R3: on a bus-cycle end the old pending value becomes active
  a_r3_switch_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    bus_end |=> act_q == $past(pend_q));
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen #(
  parameter int MAX_SHIFT = 5,
  parameter int SHW       = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SHW-1:0] shift,
  input  logic           restart,
  output logic           ce
);
  localparam int CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] mask;

  always_comb begin
    span = ({{CNT_W{1'b0}}, 1'b1} << shift) - {{CNT_W{1'b0}}, 1'b1};
    mask = span[CNT_W-1:0];
    ce   = ((cnt_q & mask) == mask);
    cnt_d = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: full speed enables every cycle
  a_r5_full_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (shift == '0) |-> ce);
  // R4: in divided mode a pulse is never two cycles wide
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && shift != '0 && !restart) |=> !ce);
  // R6: after a rate change the first divided cycle carries no pulse
  a_r6_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (shift == '0 || !ce));
endmodule

// File: rtl/acc_len_calc.sv
module acc_len_calc #(
  parameter int STATE_W   = 8,
  parameter int MAX_SHIFT = 5,
  parameter int SHW       = 3
) (
  input  logic [STATE_W-1:0]           states,
  input  logic [SHW-1:0]               shift,
  output logic [STATE_W+MAX_SHIFT-1:0] cycles
);
  localparam int OUT_W = STATE_W + MAX_SHIFT;

  always_comb begin
    cycles = OUT_W'(states) << shift;
  end
endmodule

// File: rtl/cpu_rate_ctrl.sv
module cpu_rate_ctrl #(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 5,
  parameter int STATE_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel_wr,
  input  logic [SEL_W-1:0]             sel_wdata,
  input  logic                         bus_end,
  input  logic [STATE_W-1:0]           acc_states,
  output logic                         master_ce,
  output logic                         periph_ce,
  output logic [SEL_W-1:0]             active_sel,
  output logic [STATE_W+MAX_SHIFT-1:0] acc_cycles
);
  import rate_pkg::*;

  localparam int SHW = $clog2(MAX_SHIFT + 1);

  logic [1:0]     rst_sync_q;
  logic           rst_i_n;
  logic           restart;
  logic [SHW-1:0] shift;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  rate_sel_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .bus_end(bus_end), .act_sel(active_sel), .restart(restart)
  );

  always_comb begin
    shift = SHW'(sat_shift(int'(active_sel), MAX_SHIFT));
  end

  rate_strobe_gen #(.MAX_SHIFT(MAX_SHIFT), .SHW(SHW)) u_strobe (
    .clk(clk), .rst_n(rst_i_n), .shift(shift), .restart(restart), .ce(master_ce)
  );

  acc_len_calc #(.STATE_W(STATE_W), .MAX_SHIFT(MAX_SHIFT), .SHW(SHW)) u_calc (
    .states(acc_states), .shift(shift), .cycles(acc_cycles)
  );

  assign periph_ce = rst_i_n | ~rst_i_n;

  // R10: an internal reset leaves full speed on the next edge
  a_r10_reset_full_speed: assert property (@(posedge clk)
    $fell(rst_i_n) |=> (active_sel == '0));
endmodule

// File: tb/cpu_rate_ctrl_tb.sv
module cpu_rate_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_wr;
  logic [2:0]  sel_wdata;
  logic        bus_end;
  logic [7:0]  acc_states;
  logic        master_ce, periph_ce;
  logic [2:0]  active_sel;
  logic [12:0] acc_cycles;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  cpu_rate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .bus_end(bus_end), .acc_states(acc_states), .master_ce(master_ce),
    .periph_ce(periph_ce), .active_sel(active_sel), .acc_cycles(acc_cycles)
  );

  // code, expected divider exponent
  localparam int NV = 8;
  localparam int VCODE[NV] = '{1, 2, 3, 4, 5, 6, 7, 0};
  localparam int VSH[NV]   = '{1, 2, 3, 4, 5, 5, 5, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_code(input logic [2:0] c);
    sel_wr = 1'b1; sel_wdata = c; step(); sel_wr = 1'b0;
  endtask

  task automatic end_cycle();
    bus_end = 1'b1; step(); bus_end = 1'b0;
  endtask

  // samples until master_ce is seen, first sample counts as 1
  task automatic wait_ce(output int n, output bit periph_ok);
    n = 1; periph_ok = 1'b1;
    while (!master_ce && n < 100) begin
      if (!periph_ce) periph_ok = 1'b0;
      step(); n++;
    end
    if (!periph_ce) periph_ok = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, last;
    bit pok;
    rst_n = 1'b0; sel_wr = 1'b0; sel_wdata = '0; bus_end = 1'b0; acc_states = 8'd5;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    check(active_sel == 3'd0, "R1 active code", active_sel, 0);
    check(acc_cycles == 13'd5, "R1 acc_cycles", acc_cycles, 5);
    n = 0;
    for (int i = 0; i < 6; i++) begin if (master_ce) n++; step(); end
    check(n == 6, "R1 ce every cycle", n, 6);

    // R4 R6 R8 R9 table walk
    for (int v = 0; v < NV; v++) begin
      write_code(3'(VCODE[v]));
      end_cycle();
      check(active_sel == 3'(VCODE[v]), "R4 active code", active_sel, VCODE[v]);
      check(acc_cycles == 13'(5 << VSH[v]), "R9 acc_cycles", acc_cycles, 5 << VSH[v]);
      wait_ce(n, pok);
      check(n == (1 << VSH[v]), "R6 first pulse", n, 1 << VSH[v]);
      step();
      wait_ce(n, pok);
      check(n == (1 << VSH[v]), "R4 pulse spacing", n, 1 << VSH[v]);
      check(pok, "R8 periph_ce", pok, 1);
    end

    // R5 full speed after return to code 0
    n = 0;
    for (int i = 0; i < 5; i++) begin if (master_ce) n++; step(); end
    check(n == 5, "R5 ce every cycle", n, 5);

    // R9 at /4
    write_code(3'd2); end_cycle();
    acc_states = 8'd4; step();
    check(acc_cycles == 13'd16, "R9 4 states at /4", acc_cycles, 16);
    acc_states = 8'd8; step();
    check(acc_cycles == 13'd32, "R9 8 states at /4", acc_cycles, 32);

    // R7 bus_end with unchanged code keeps phase
    wait_ce(n, pok);
    step();            // 1 after pulse
    end_cycle();       // 2 after pulse
    last = 2;
    wait_ce(n, pok);
    check(last + n - 1 == 4, "R7 phase kept", last + n - 1, 4);

    // R3 write in the same cycle as bus_end
    sel_wr = 1'b1; sel_wdata = 3'd3; bus_end = 1'b1; step();
    sel_wr = 1'b0; bus_end = 1'b0;
    check(active_sel == 3'd2, "R3 same-cycle write deferred", active_sel, 2);
    end_cycle();
    check(active_sel == 3'd3, "R3 pending applied", active_sel, 3);

    // R2 written code held while no bus end
    write_code(3'd4);
    repeat (10) step();
    check(active_sel == 3'd3, "R2 held pending", active_sel, 3);
    end_cycle();
    check(active_sel == 3'd4, "R2 applied at end", active_sel, 4);

    // R10 asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    check(active_sel == 3'd0, "R10 reset code", active_sel, 0);
    check(master_ce == 1'b1, "R10 reset ce", master_ce, 1);
    step(); rst_n = 1'b1;
    repeat (3) step();
    check(master_ce == 1'b1 && active_sel == 3'd0, "R10 after release", master_ce, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule